// File: doc/BRIEF.md
# Freezable DC-Offset Removal Filter

This block takes decimated ADC samples, one channel at a time, and removes any DC level from them. Each channel keeps its own running estimate of its DC level. The estimate is a first-order leaky integrator whose coefficient is a power of two. The current estimate is subtracted from every incoming sample, and the result is clipped to the sample width.

Each channel also has a hold input. While a channel's hold bit is high, that channel's estimate stops adapting, but the held value is still subtracted from every sample. A system offset calibration therefore works in two steps: let the filter run until the estimate settles, then raise the hold bit. The stored estimate then acts as a fixed correction for everything upstream of the block. When the hold bit drops, adaptation picks up again from the held value.

Top module: `dc_trim_filter`

## Requirements
- R1: Reset clears every channel's estimate to zero and drives out_valid low. The first sample on any channel after reset comes out unchanged.
- R2: An accepted sample (in_valid high) appears at the output exactly one cycle later. out_valid is high, out_ch equals the sample's channel, and out_data equals the sample minus that channel's estimate as it stood before this sample.
- R3: Each channel's accumulator has K fractional bits. The estimate is the accumulator shifted right arithmetically by K (rounding toward minus infinity). An unheld sample x updates the accumulator by adding ((x·2^K − acc) >>> K).
- R4: While hold[c] is high, a sample on channel c leaves channel c's accumulator unchanged, and the held estimate is still subtracted from that sample.
- R5: A sample on channel c changes no other channel's accumulator.
- R6: After hold[c] falls, adaptation continues from the held accumulator, not from zero.
- R7: out_data is saturated to the signed range of W bits: [−2^(W−1), 2^(W−1)−1].
- R8: A cycle with in_valid low changes no accumulator and gives out_valid low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_ch | input | $clog2(CH) | Channel index of the sample |
| in_data | input | W | Signed input sample |
| hold | input | CH | Per-channel estimate freeze |
| out_valid | output | 1 | Corrected sample strobe |
| out_ch | output | $clog2(CH) | Channel index of the corrected sample |
| out_data | output | W | Signed, saturated corrected sample |

## Verification
A wrong accumulator value shows at the ports on the next sample for that channel, one cycle after the sample is accepted, as a shifted out_data value. An error below 2^K in the accumulator's fractional bits can stay hidden until enough samples carry it into the estimate. For that reason, long runs of a constant level are compared against a bench model of the integrator, sample by sample. A hold bit that leaks, or a write that lands on the wrong channel, appears as a changed offset on the held or untouched channel the next time that channel is sampled.

// File: rtl/dc_trim_filter.sv
module dc_trim_filter #(
  parameter int CH = 4,
  parameter int W  = 24,
  parameter int K  = 12,
  localparam int CW = (CH > 1) ? $clog2(CH) : 1,
  localparam int AW = W + K + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [CW-1:0]       in_ch,
  input  logic signed [W-1:0] in_data,
  input  logic [CH-1:0]       hold,
  output logic                out_valid,
  output logic [CW-1:0]       out_ch,
  output logic signed [W-1:0] out_data
);

  localparam logic signed [AW-1:0] SMAX = {{(AW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [AW-1:0] SMIN = {{(AW-W+1){1'b1}}, {(W-1){1'b0}}};

  logic signed [AW-1:0] acc [CH];
  logic signed [AW-1:0] cur, xs, xe, est, nxt, res;
  logic signed [W-1:0]  sat;

  assign cur = acc[in_ch];
  assign xe  = {{(AW-W){in_data[W-1]}}, in_data};
  assign xs  = {{(AW-W-K){in_data[W-1]}}, in_data, {K{1'b0}}};
  assign nxt = cur + ((xs - cur) >>> K);
  assign est = cur >>> K;
  assign res = xe - est;
  assign sat = (res > SMAX) ? SMAX[W-1:0] :
               (res < SMIN) ? SMIN[W-1:0] : res[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < CH; c++) acc[c] <= '0;
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_ch   <= in_ch;
        out_data <= sat;
        if (!hold[in_ch]) acc[in_ch] <= nxt;
      end
    end
  end

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  a_r2_channel_echo: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) |-> out_ch == $past(in_ch));

  for (genvar c = 0; c < CH; c++) begin : g_chk
    a_r4_r5_acc_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_ch == CW'(c) && !hold[c]) |=> $stable(acc[c]));
  end

  a_r7_saturated: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid) && $past(res) > SMAX) |-> out_data == SMAX[W-1:0]);

endmodule

// File: tb/dc_trim_filter_tb_top.sv
module dc_trim_filter_tb_top;
  localparam int CH = 4;
  localparam int W  = 16;
  localparam int K  = 4;
  localparam int CW = 2;
  localparam time PERIOD = 10ns;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [CW-1:0] in_ch = 0;
  logic signed [W-1:0] in_data = 0;
  logic [CH-1:0] hold = 0;
  logic out_valid;
  logic [CW-1:0] out_ch;
  logic signed [W-1:0] out_data;

  int vectors = 0, miscompares = 0;
  longint accm [CH];
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  dc_trim_filter #(.CH(CH), .W(W), .K(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch),
    .in_data(in_data), .hold(hold), .out_valid(out_valid),
    .out_ch(out_ch), .out_data(out_data));

  function automatic longint clip(longint v);
    longint hi = (longint'(1) <<< (W-1)) - 1;
    longint lo = -(longint'(1) <<< (W-1));
    return (v > hi) ? hi : (v < lo) ? lo : v;
  endfunction

  task automatic apply(bit v, int ch, longint x, logic [CH-1:0] fr, string tag);
    longint exp_y = 0;
    in_valid = v; in_ch = ch[CW-1:0]; in_data = x[W-1:0]; hold = fr;
    if (v) begin
      exp_y = clip(x - (accm[ch] >>> K));
      if (!fr[ch]) accm[ch] += (((x <<< K) - accm[ch]) >>> K);
    end
    @(negedge clk);
    vectors++;
    if (out_valid !== v) begin
      miscompares++;
      $display("FAIL %s out_valid=%0b expected %0b", tag, out_valid, v);
    end else if (v && (longint'(out_data) != exp_y || out_ch != ch[CW-1:0])) begin
      miscompares++;
      $display("FAIL %s ch=%0d data=%0d expected ch=%0d data=%0d",
               tag, out_ch, out_data, ch, exp_y);
    end
  endtask

  initial begin
    #(PERIOD*150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    longint held;
    void'($urandom(32'd4711));
    for (int c = 0; c < CH; c++) accm[c] = 0;
    repeat (3) @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 out_valid=%0b expected 0 in reset", out_valid);
    end
    rst_n = 1;
    @(negedge clk);
    apply(1, 3, 5000, 0, "R1");
    apply(1, 0, -1234, 0, "R1");
    for (int i = 0; i < 300; i++) apply(1, 1, 1000, 0, "R3");
    for (int i = 0; i < 20; i++) apply(1, 1, 0, 4'b0010, "R4");
    held = accm[1];
    for (int i = 0; i < 20; i++) apply(1, 1, 500 - 50*i, 4'b0010, "R4");
    apply(0, 1, 9999, 0, "R8");
    apply(1, 1, 0, 0, "R6");
    apply(1, 1, 0, 0, "R6");
    if (held == 0) begin
      miscompares++;
      $display("FAIL R6 held estimate 0 expected nonzero");
    end
    for (int i = 0; i < 10; i++) apply(1, 2, 7, 0, "R5");
    for (int i = 0; i < 300; i++) apply(1, 0, 32767, 0, "R3");
    apply(1, 0, -32768, 0, "R7");
    for (int i = 0; i < 300; i++) apply(1, 2, -32768, 0, "R3");
    apply(1, 2, 32767, 0, "R7");
    for (int i = 0; i < 4000; i++) begin
      logic [CH-1:0] fr;
      int ch = $urandom_range(0, CH-1);
      longint x;
      for (int b = 0; b < CH; b++) fr[b] = ($urandom_range(0, 3) == 0);
      x = (i % 3 == 0) ? longint'($urandom_range(0, 200)) - 100
                       : longint'($urandom_range(0, 65535)) - 32768;
      apply($urandom_range(0, 7) != 0, ch, x, fr, "R2");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule